// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software with a 7-bit down-counter that software must reload inside a timing window. The counter steps down once per prescaled period. The period is a fixed base divide, set by the `BASE_DIV` parameter (4096 by default), multiplied by 1, 2, 4 or 8. Once the watchdog is armed, a one-cycle reset request goes out in four cases: the counter drops out of its upper half (bit 6 clears on a decrement), software reloads it while it still sits above the programmed window, software loads a value whose bit 6 is zero, or software arms the watchdog with such a value.

A warning flag rises one step before the counter leaves its upper half. It drives an interrupt output once the interrupt has been enabled. Software reaches the block through a synchronous write port and a combinational read port that select one of three registers: control, configuration and status. The arming bit and the interrupt enable can only be set by software. Only a reset clears them.

Top module: `win_watchdog`

## Requirements
- R1: The counter (control bits [6:0]) decrements by one, wrapping from 0x00 to 0x7F, once every BASE_DIV × 2^P clock cycles. P is the 2-bit prescale field in configuration bits [8:7].
- R2: While armed, a decrement from 0x40 to 0x3F raises `rst_req` for exactly the one cycle after the clock edge that makes that step.
- R3: When a control write (select 0) leaves the block armed and the written bit 6 is 0, `rst_req` is high in the cycle after the write.
- R4: When an armed control write happens while the current counter is greater than the window (configuration bits [6:0]), `rst_req` pulses. A write at or below the window with bit 6 set raises no request.
- R5: While not armed, `rst_req` stays low and the counter keeps counting.
- R6: The arming bit (control bit 7) is set by writing 1 to it. Control writes with bit 7 at 0 leave it set.
- R7: The warning flag (status bit 0, select 2) is set on the decrement from 0x41 to 0x40, whether or not the interrupt is enabled.
- R8: A status write with bit 0 at 0 clears the flag, and a write with bit 0 at 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R9: The interrupt enable (configuration bit 9, select 1) is sticky once set. `irq` equals flag AND enable.
- R10: Every control write loads the counter and restarts the prescale divider, so the next decrement comes one full period later. A load wins over a decrement that falls in the same cycle, and no edge request is raised.
- R11: After reset the counter reads 0x7F, the window 0x7F, the prescale field 0, and the arming bit, interrupt enable and flag 0. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select: 0 control, 1 configuration, 2 status |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read register select, same coding as `wr_sel` |
| rd_data | output | 16 | Read data for `rd_sel` |
| irq | output | 1 | Early-warning interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of events can fall in the same cycle. A control reload can meet a prescaler decrement, and a software clear of the flag can meet the hardware set of the flag. The bench uses its reference model's divider phase to find the clock edge on which the counter at 0x40 (or 0x41) is about to step. It drives the control write (or the status clear) exactly onto that edge. It then checks that the reload wins with no edge request, and that the set wins over the clear. A behavioural model is also compared against every output on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W         = 7;
  localparam int TB_W          = 2;
  localparam int DATA_W        = 16;
  localparam int CTRL_EN_BIT   = 7;
  localparam int CFG_TB_LSB    = 7;
  localparam int CFG_IE_BIT    = 9;
  localparam int STAT_FLAG_BIT = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_RSVD = 2'd3
  } wdt_sel_e;
endpackage

// File: rtl/wdt_divider.sv
module wdt_divider #(
  parameter int BASE_DIV = 4096,
  parameter int TB_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [TB_W-1:0] tb,
  output logic            tick
);
  localparam int MAX_SPAN = BASE_DIV << ((1 << TB_W) - 1);
  localparam int DIV_W    = $clog2(MAX_SPAN);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W:0]   span;

  // the period follows the live prescale field; a stale phase above a
  // shortened period ticks at once instead of running away
  always_comb begin
    span  = (DIV_W+1)'(BASE_DIV) << tb;
    tick  = ({1'b0, div_q} >= (span - 1'b1));
    div_d = (clr || tick) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ld_arm,
  input  logic             armed,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] cnt,
  output logic             warn_hit,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] EDGE_VAL = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WARN_PRE = EDGE_VAL + 1'b1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  always_comb begin
    cnt_d    = cnt_q;
    req_d    = 1'b0;
    warn_hit = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
      req_d = (armed || ld_arm) && (!ld_val[CNT_W-1] || (cnt_q > window));
    end else if (tick) begin
      cnt_d    = cnt_q - 1'b1;
      req_d    = armed && (cnt_q == EDGE_VAL);
      warn_hit = (cnt_q == WARN_PRE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      req_q <= 1'b0;
    end else begin
      if (ld || tick) cnt_q <= cnt_d;
      req_q <= req_d;
    end
  end

  assign cnt     = cnt_q;
  assign rst_req = req_q;

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld) |=> (cnt == $past(cnt) - 1'b1));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld) |=> $stable(cnt));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
  assert_low_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && (armed || ld_arm) && !ld_val[CNT_W-1]) |=> rst_req);
  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(ld && ld_arm)) |=> !rst_req);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_DIV = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              rst_req
);
  logic [1:0] sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_int_n = sync_q[1];

  wdt_sel_e wsel, rsel;
  assign wsel = wdt_sel_e'(wr_sel);
  assign rsel = wdt_sel_e'(rd_sel);

  logic ctrl_wr, cfg_wr, stat_wr;
  assign ctrl_wr = wr_en && (wsel == SEL_CTRL);
  assign cfg_wr  = wr_en && (wsel == SEL_CFG);
  assign stat_wr = wr_en && (wsel == SEL_STAT);

  logic             en_q, en_d, ie_q, ie_d, flag_q, flag_d;
  logic [CNT_W-1:0] win_q, win_d;
  logic [TB_W-1:0]  tb_q, tb_d;
  logic [CNT_W-1:0] cnt;
  logic             tick, warn_hit;

  wdt_divider #(.BASE_DIV(BASE_DIV), .TB_W(TB_W)) u_div (
    .clk(clk), .rst_n(rst_int_n), .clr(ctrl_wr), .tb(tb_q), .tick(tick)
  );

  wdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .ld(ctrl_wr),
    .ld_val(wr_data[CNT_W-1:0]), .ld_arm(wr_data[CTRL_EN_BIT]),
    .armed(en_q), .window(win_q), .cnt(cnt), .warn_hit(warn_hit),
    .rst_req(rst_req)
  );

  always_comb begin
    en_d   = en_q | wr_data[CTRL_EN_BIT];
    win_d  = wr_data[CNT_W-1:0];
    tb_d   = wr_data[CFG_TB_LSB +: TB_W];
    ie_d   = ie_q | wr_data[CFG_IE_BIT];
    flag_d = flag_q;
    if (stat_wr && !wr_data[STAT_FLAG_BIT]) flag_d = 1'b0;
    if (warn_hit)                           flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      win_q  <= '1;
      tb_q   <= '0;
    end else begin
      if (ctrl_wr) en_q <= en_d;
      if (cfg_wr) begin
        win_q <= win_d;
        tb_q  <= tb_d;
        ie_q  <= ie_d;
      end
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rsel)
      SEL_CTRL: begin
        rd_data[CNT_W-1:0]   = cnt;
        rd_data[CTRL_EN_BIT] = en_q;
      end
      SEL_CFG: begin
        rd_data[CNT_W-1:0]               = win_q;
        rd_data[CFG_TB_LSB +: TB_W]      = tb_q;
        rd_data[CFG_IE_BIT]              = ie_q;
      end
      SEL_STAT: rd_data[STAT_FLAG_BIT] = flag_q;
      default:  rd_data = '0;
    endcase
  end

  assign irq = flag_q & ie_q;

  assert_en_sticky_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    en_q |=> en_q);
  assert_ie_sticky_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ie_q |=> ie_q);
  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    warn_hit |=> flag_q);
endmodule

// File: tb/win_watchdog_tb.sv
`timescale 1ns/1ps
module win_watchdog_tb;
  localparam int BD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        irq, rst_req;

  always #2.5 clk = ~clk;

  win_watchdog #(.BASE_DIV(BD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .rst_req(rst_req)
  );

  int n_chk = 0, n_fail = 0;
  int m_cnt = 127, m_en = 0, m_win = 127, m_tb = 0, m_ie = 0;
  int m_flag = 0, m_div = 0, m_rst = 0, seen = 0;
  bit cmp_on = 1'b0, rst_seen = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int span, tick, n_rst, ctrlw, cfgw, statw, ncnt, nflag;
    span  = BD << m_tb;
    tick  = (m_div >= span - 1) ? 1 : 0;
    ctrlw = (wr_en && wr_sel == 2'd0) ? 1 : 0;
    cfgw  = (wr_en && wr_sel == 2'd1) ? 1 : 0;
    statw = (wr_en && wr_sel == 2'd2) ? 1 : 0;
    n_rst = 0;
    ncnt  = m_cnt;
    nflag = m_flag;
    if (statw && !wr_data[0]) nflag = 0;
    if (ctrlw) begin
      if ((m_en || wr_data[7]) && (!wr_data[6] || m_cnt > m_win)) n_rst = 1;
      ncnt = int'(wr_data[6:0]);
    end else if (tick) begin
      if (m_en && m_cnt == 64) n_rst = 1;
      if (m_cnt == 65) nflag = 1;
      ncnt = (m_cnt + 127) % 128;
    end
    m_div = (ctrlw || tick) ? 0 : m_div + 1;
    if (ctrlw && wr_data[7]) m_en = 1;
    if (cfgw) begin
      m_win = int'(wr_data[6:0]);
      m_tb  = int'(wr_data[8:7]);
      if (wr_data[9]) m_ie = 1;
    end
    m_cnt = ncnt; m_flag = nflag; m_rst = n_rst;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 127; m_en = 0; m_win = 127; m_tb = 0; m_ie = 0;
      m_flag = 0; m_div = 0; m_rst = 0; seen = 0;
    end else begin
      seen++;
      if (seen >= 3) model_step();
    end
  end

  function automatic logic [15:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0:    return 16'((m_en << 7) | m_cnt);
      2'd1:    return 16'((m_ie << 9) | (m_tb << 7) | m_win);
      2'd2:    return 16'(m_flag);
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R2 rst_req vs model", 32'(rst_req), 32'(m_rst));
      chk("R9 irq vs model", 32'(irq), 32'(m_flag & m_ie));
      chk("R1 rd_data vs model", 32'(rd_data), 32'(exp_rd(rd_sel)));
    end
    if (rst_req) rst_seen = 1'b1;
  end

  task automatic wr(logic [1:0] s, logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 16'd0;
  endtask

  task automatic peek(logic [1:0] s, output logic [15:0] v);
    rd_sel = s;
    #1;
    v = rd_data;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cmp_on = 1'b1;

    // reset state
    peek(2'd0, v); chk("R11 control reset", 32'(v), 32'h7F);
    peek(2'd1, v); chk("R11 config reset", 32'(v), 32'h7F);
    peek(2'd2, v); chk("R11 status reset", 32'(v), 32'h0);
    peek(2'd3, v); chk("R11 reserved select", 32'(v), 32'h0);
    chk("R11 rst_req idle", 32'(rst_req), 32'h0);

    // disarmed run through the edge
    rst_seen = 1'b0;
    while (m_cnt != 64) @(negedge clk);
    peek(2'd2, v); chk("R7 flag with irq disabled", 32'(v), 32'h1);
    chk("R9 irq masked", 32'(irq), 32'h0);
    while (m_cnt != 60) @(negedge clk);
    chk("R5 no request while disarmed", 32'(rst_seen), 32'h0);
    peek(2'd0, v); chk("R5 counter keeps running", 32'(v), 32'h3C);

    // flag clear semantics
    @(negedge clk); wr(2'd2, 16'h0001);
    peek(2'd2, v); chk("R8 writing 1 keeps flag", 32'(v), 32'h1);
    wr(2'd2, 16'h0000);
    peek(2'd2, v); chk("R8 writing 0 clears flag", 32'(v), 32'h0);

    // arm, sticky enable
    wr(2'd0, 16'h00FF);
    chk("R4 legal arming write", 32'(rst_req), 32'h0);
    wr(2'd0, 16'h007F);
    peek(2'd0, v); chk("R6 enable stays set", 32'(v[7]), 32'h1);
    wr(2'd1, 16'h02D0);
    peek(2'd1, v); chk("R9 config readback", 32'(v), 32'h2D0);

    // early refresh
    wr(2'd0, 16'h007F);
    chk("R4 early refresh requests reset", 32'(rst_req), 32'h1);
    @(negedge clk);
    chk("R2 request is one cycle", 32'(rst_req), 32'h0);

    // legal refresh and divider restart
    while (m_cnt != 80) @(negedge clk);
    wr(2'd0, 16'h007F);
    chk("R4 refresh inside window", 32'(rst_req), 32'h0);
    repeat (7) @(negedge clk);
    peek(2'd0, v); chk("R10 full period after reload", 32'(v), 32'hFF);
    @(negedge clk);
    peek(2'd0, v); chk("R1 step after P=1 period", 32'(v), 32'hFE);

    // bit 6 clear load
    while (m_cnt != 72) @(negedge clk);
    wr(2'd0, 16'h0030);
    chk("R3 low value load requests reset", 32'(rst_req), 32'h1);
    wr(2'd0, 16'h007F);

    // late: edge crossing with interrupt
    wr(2'd1, 16'h02FF);
    while (m_cnt != 64) @(negedge clk);
    peek(2'd2, v); chk("R7 flag at 0x40", 32'(v), 32'h1);
    chk("R9 irq follows flag", 32'(irq), 32'h1);
    while (m_cnt != 63) @(negedge clk);
    chk("R2 edge request", 32'(rst_req), 32'h1);

    // set beats clear
    @(negedge clk); wr(2'd2, 16'h0000);
    peek(2'd2, v); chk("R8 clear before collision", 32'(v), 32'h0);
    wr(2'd0, 16'h0042);
    while (!(m_cnt == 65 && m_div == (BD << m_tb) - 1)) @(negedge clk);
    wr(2'd2, 16'h0000);
    peek(2'd2, v); chk("R8 hardware set wins over clear", 32'(v), 32'h1);
    while (m_cnt != 63) @(negedge clk);
    chk("R2 edge request again", 32'(rst_req), 32'h1);

    // load beats tick at the edge
    @(negedge clk); wr(2'd0, 16'h0041);
    while (!(m_cnt == 64 && m_div == (BD << m_tb) - 1)) @(negedge clk);
    wr(2'd0, 16'h007F);
    chk("R10 load beats edge tick", 32'(rst_req), 32'h0);
    peek(2'd0, v); chk("R10 loaded value kept", 32'(v), 32'hFF);

    // longest prescale
    wr(2'd1, 16'h03FF);
    wr(2'd0, 16'h007F);
    repeat (31) @(negedge clk);
    peek(2'd0, v); chk("R1 hold through P=3 period", 32'(v), 32'hFF);
    @(negedge clk);
    peek(2'd0, v); chk("R1 step after P=3 period", 32'(v), 32'hFE);

    // sticky interrupt enable
    wr(2'd1, 16'h007F);
    peek(2'd1, v); chk("R9 irq enable sticky", 32'(v), 32'h27F);
    wr(2'd0, 16'h007F);
    peek(2'd0, v); chk("R6 enable sticky after bit7=0", 32'(v[7]), 32'h1);

    repeat (4) @(negedge clk);
    cmp_on = 1'b0;
    summary();
    $finish;
  end
endmodule